// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block sits beside a two-bank SDRAM command bus and only watches it. On every rising clock edge it samples chip select, the row and column strobes, write enable, clock enable, the auto-precharge address bit and the bank-select address bit. From these it keeps one small state machine per bank (idle, open, auto-precharging, precharging) with a shared down-counter for that bank's timing window. It also keeps one burst tracker for the shared data bus. It never drives the bus and holds no data.

When a command breaks a sequencing or timing rule, the monitor raises a sticky error flag and stores a 3-bit code that names the rule. Only the first violation is kept. Later violations are ignored until the synchronous clear input is pulsed. Burst length, the activate-to-precharge minimum and the precharge duration are parameters. A burst length of 0 selects full-page bursts.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded only when cke is high and cs_n is low, from {ras_n,cas_n,we_n}: activate 011, read 101, write 100, burst stop 110, precharge 010. a11 selects bank 0 or 1, and a10 means auto precharge on a read or write, or all banks on a precharge. After reset, err is 0 and err_code is 0. err_code is 0 whenever err is 0.
- R2: A precharge (single or all-bank) that reaches an open bank fewer than T_RAS cycles after that bank's activate sets code 1. A precharge exactly T_RAS cycles later is legal.
- R3: An activate, read or write to a bank less than T_RP cycles after its precharge command sets code 2. At exactly T_RP cycles, an activate is legal.
- R4: A read or write with a10=1 to an open bank starts auto precharge. For BURST_LEN+T_RP cycles after it, any read, write or activate to that bank sets code 3. At exactly BURST_LEN+T_RP cycles, an activate is legal.
- R5: With BURST_LEN=0 (full page), a read or write with a10=1 sets code 4 and leaves the bank open.
- R6: If cke is sampled low while neither bank is open or inside a timing window, the device is in power-down from the next cycle until cke is sampled high. During power-down, any selected command other than {ras_n,cas_n,we_n}=111 sets code 5. Deselect (cs_n=1) and no-operation are legal. While cke is low outside power-down (clock suspend), commands are ignored.
- R7: A read or write to a bank that is not open sets code 6.
- R8: A read or write to an open bank starts a burst of BURST_LEN cycles counted from the command, or an endless burst when BURST_LEN=0. A burst stop, a new read or write, or a precharge that covers the burst's bank ends it. A burst stop with no burst running sets code 7.
- R9: Only the first error is captured. err and err_code then hold until clr is sampled high, which returns both to 0. clr takes priority over an error in the same cycle.
- R10: When one command breaks several rules, the stored code follows this order: 5, 3, 2, 6, 4, 1, 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the captured error |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| a11 | input | 1 | Bank select address bit |
| err | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation |

## Verification
The bench builds two copies of the monitor on the same stimulus:
- One uses burst length 4, T_RAS 5 and T_RP 3. Its windows are long enough to hit one cycle short of each limit and the exact limit cycle for activate-to-precharge, precharge recovery and the seven-cycle auto-precharge window.
- The other uses full-page bursts with T_RAS 3 and T_RP 2. It reaches the full-page auto-precharge error and a burst that never ends by itself.

Because the two copies have different limits, the same command sequence lands on opposite sides of a timing boundary in each copy.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BURST_LEN = 4,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       a10,
  input  logic       a11,
  output logic       err,
  output logic [2:0] err_code
);
  localparam bit FULL_PAGE = (BURST_LEN == 0);
  localparam int BL_EFF    = FULL_PAGE ? 1 : BURST_LEN;
  localparam int AP_WIN    = BL_EFF + T_RP;
  localparam int CMAX      = (T_RAS > AP_WIN) ? T_RAS : AP_WIN;
  localparam int CW        = $clog2(CMAX + 1);
  localparam int BW        = $clog2(BL_EFF + 1);

  typedef enum logic [1:0] {B_IDLE, B_OPEN, B_AUTOPRE, B_PRE} bank_st_t;

  logic [3:0] pins;
  logic is_act, is_rd, is_wr, is_rw, is_bst, is_pre;
  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_act = cke && pins == 4'b0011;
  assign is_rd  = cke && pins == 4'b0101;
  assign is_wr  = cke && pins == 4'b0100;
  assign is_bst = cke && pins == 4'b0110;
  assign is_pre = cke && pins == 4'b0010;
  assign is_rw  = is_rd || is_wr;

  logic [1:0] is_open, ap_busy, rp_busy, tras_early, is_idle, pre_hit;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    bank_st_t     st;
    logic [CW-1:0] tcnt;
    logic          hit;
    assign hit           = (int'(a11) == b);
    assign pre_hit[b]    = is_pre && (a10 || hit);
    assign is_open[b]    = (st == B_OPEN);
    assign tras_early[b] = is_open[b] && tcnt != '0;
    assign ap_busy[b]    = (st == B_AUTOPRE) && tcnt != '0;
    assign rp_busy[b]    = (st == B_PRE) && tcnt != '0;
    assign is_idle[b]    = (st == B_IDLE) || (!is_open[b] && tcnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st   <= B_IDLE;
        tcnt <= '0;
      end else begin
        case (st)
          B_OPEN: begin
            if (pre_hit[b]) begin
              st   <= B_PRE;
              tcnt <= CW'(T_RP - 1);
            end else if (is_rw && hit && a10 && !FULL_PAGE) begin
              st   <= B_AUTOPRE;
              tcnt <= CW'(AP_WIN - 1);
            end else if (tcnt != '0) begin
              tcnt <= tcnt - 1'b1;
            end
          end
          default: begin
            if (tcnt != '0) begin
              tcnt <= tcnt - 1'b1;
            end else if (is_act && hit) begin
              st   <= B_OPEN;
              tcnt <= CW'(T_RAS - 1);
            end else begin
              st <= B_IDLE;
            end
          end
        endcase
      end
    end
  end

  logic          brun, bbank, pd;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brun  <= 1'b0;
      bcnt  <= '0;
      bbank <= 1'b0;
    end else if (is_rw && is_open[a11]) begin
      brun  <= FULL_PAGE || (BURST_LEN > 1);
      bcnt  <= BW'(BL_EFF - 1);
      bbank <= a11;
    end else if (is_bst || (is_pre && (a10 || a11 == bbank))) begin
      brun <= 1'b0;
    end else if (brun && !FULL_PAGE && cke) begin
      if (bcnt == BW'(1)) brun <= 1'b0;
      bcnt <= bcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd <= 1'b0;
    else        pd <= !cke && (pd || (&is_idle));
  end

  logic       e_pd;
  logic [2:0] code_now;
  assign e_pd = pd && !cke && !cs_n && !(ras_n && cas_n && we_n);

  always_comb begin
    if (e_pd)                                     code_now = 3'd5;
    else if ((is_rw || is_act) && ap_busy[a11])   code_now = 3'd3;
    else if ((is_rw || is_act) && rp_busy[a11])   code_now = 3'd2;
    else if (is_rw && !is_open[a11])              code_now = 3'd6;
    else if (is_rw && a10 && FULL_PAGE)           code_now = 3'd4;
    else if (|(pre_hit & tras_early))             code_now = 3'd1;
    else if (is_bst && !brun)                     code_now = 3'd7;
    else                                          code_now = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err      <= 1'b0;
      err_code <= 3'd0;
    end else if (clr) begin
      err      <= 1'b0;
      err_code <= 3'd0;
    end else if (!err && code_now != 3'd0) begin
      err      <= 1'b1;
      err_code <= code_now;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       a10,
  input logic       err,
  input logic [2:0] err_code
);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> err_code == 3'd0);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr |=> err && $stable(err_code));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err && err_code == 3'd0);

  p_tras_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) && err_code == 3'd1 |-> $past(cke && !cs_n && !ras_n && cas_n && !we_n));

  p_fullpage_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) && err_code == 3'd4 |-> $past(cke && !cs_n && ras_n && !cas_n && a10));

  p_pdown_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) && err_code == 3'd5 |-> $past(!cke && !cs_n));

  p_stop_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) && err_code == 3'd7 |-> $past(cke && !cs_n && ras_n && cas_n && !we_n));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .a10(a10), .err(err), .err_code(err_code)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_BST = 4'b0110, C_PRE = 4'b0010,
                         C_DES = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0, a11 = 1'b0;
  logic       err, err_fp;
  logic [2:0] err_code, code_fp;

  always #5 clk = ~clk;

  sdram_cmd_monitor #(.BURST_LEN(4), .T_RAS(5), .T_RP(3)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .a11(a11), .err(err), .err_code(err_code));

  sdram_cmd_monitor #(.BURST_LEN(0), .T_RAS(3), .T_RP(2)) dut_fp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .a11(a11), .err(err_fp), .err_code(code_fp));

  typedef struct {
    bit         fp;
    logic [2:0] code;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   nvec = 0, nbad = 0;
  bit   done = 1'b0;

  task automatic cyc(input logic [3:0] c, input logic av = 1'b0,
                     input logic bv = 1'b0, input logic kv = 1'b1);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    a10 = av; a11 = bv; cke = kv; clr = 1'b0;
    @(posedge clk);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) cyc(C_NOP);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0; {cs_n, ras_n, cas_n, we_n} = C_NOP; cke = 1'b1; clr = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = C_NOP; cke = 1'b1; clr = 1'b1;
    @(posedge clk);
  endtask

  task automatic expect2(input logic [2:0] cd, input logic [2:0] cf, input string tag);
    q.push_back('{1'b0, cd, tag});
    q.push_back('{1'b1, cf, tag});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t it;
        logic       ae;
        logic [2:0] ac;
        it = q.pop_front();
        ae = it.fp ? err_fp : err;
        ac = it.fp ? code_fp : err_code;
        nvec++;
        if (ae !== (it.code != 3'd0) || ac !== it.code) begin
          nbad++;
          $display("FAIL %s [%s]: err=%0b code=%0d expected err=%0b code=%0d",
                   it.tag, it.fp ? "fullpage" : "bl4", ae, ac, it.code != 3'd0, it.code);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nbad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    restart(); cyc(C_NOP);
    expect2(0, 0, "R1 reset state");

    // R2 exact tRAS boundary, read to open bank legal (R7)
    restart(); cyc(C_ACT); cyc(C_RD); nop(3); cyc(C_PRE);
    expect2(0, 0, "R2 precharge at T_RAS");

    // R2 early single precharge
    restart(); cyc(C_ACT, 0, 1); nop(3); cyc(C_PRE, 0, 1);
    expect2(1, 0, "R2 precharge one short of T_RAS");

    // R2 precharge-all hits the younger bank
    restart(); cyc(C_ACT, 0, 0); cyc(C_ACT, 0, 1); nop(3); cyc(C_PRE, 1, 0);
    expect2(1, 0, "R2 precharge all early");

    // R3 activate during precharge
    restart(); cyc(C_ACT); nop(4); cyc(C_PRE); cyc(C_NOP); cyc(C_ACT);
    expect2(2, 0, "R3 activate before T_RP");
    restart(); cyc(C_ACT); nop(4); cyc(C_PRE); nop(2); cyc(C_ACT);
    expect2(0, 0, "R3 activate at T_RP");

    // R4 / R5 auto precharge read
    restart(); cyc(C_ACT); nop(4); cyc(C_RD, 1, 0); nop(2); cyc(C_ACT);
    expect2(3, 4, "R4 R5 activate inside auto-precharge window");
    restart(); cyc(C_ACT); nop(4); cyc(C_RD, 1, 0); nop(5); cyc(C_ACT);
    expect2(3, 4, "R4 activate one short of window end");
    restart(); cyc(C_ACT); nop(4); cyc(C_RD, 1, 0); nop(6); cyc(C_ACT);
    expect2(0, 4, "R4 activate at window end");
    restart(); cyc(C_ACT, 0, 1); nop(4); cyc(C_WR, 1, 1); cyc(C_RD, 0, 1);
    expect2(3, 4, "R4 read after auto-precharge write");

    // R7 / R10 access to idle bank
    restart(); cyc(C_WR, 0, 0);
    expect2(6, 6, "R7 write to idle bank");
    restart(); cyc(C_RD, 1, 0);
    expect2(6, 6, "R10 not-open outranks full-page code");

    // R6 power-down
    restart(); cyc(C_NOP, 0, 0, 0); cyc(C_ACT, 0, 0, 0);
    expect2(5, 5, "R6 command in power-down");
    restart(); cyc(C_NOP, 0, 0, 0); cyc(C_NOP, 0, 0, 0); cyc(C_DES, 0, 0, 0);
    cyc(C_NOP); cyc(C_ACT);
    expect2(0, 0, "R6 nop and deselect in power-down");
    restart(); cyc(C_ACT); cyc(C_RD, 0, 1, 0); cyc(C_WR, 0, 1, 0);
    expect2(0, 0, "R6 commands ignored in clock suspend");

    // R8 burst tracking
    restart(); cyc(C_ACT); nop(4); cyc(C_RD); nop(2); cyc(C_BST);
    expect2(0, 0, "R8 stop inside burst");
    cyc(C_BST);
    expect2(7, 7, "R8 second stop with no burst");
    restart(); cyc(C_ACT); nop(4); cyc(C_RD); nop(3); cyc(C_BST);
    expect2(7, 0, "R8 stop after burst end vs full page");
    restart(); cyc(C_ACT); nop(4); cyc(C_RD); cyc(C_PRE); cyc(C_BST);
    expect2(7, 7, "R8 precharge ends burst");

    // R9 sticky first error and clear
    restart(); cyc(C_ACT, 0, 1); nop(3); cyc(C_PRE, 0, 1); cyc(C_BST);
    expect2(1, 7, "R9 first code held");
    clear_pulse();
    expect2(0, 0, "R9 clear");
    cyc(C_RD, 0, 0);
    expect2(6, 6, "R9 capture after clear");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule